// File: doc/BRIEF.md
# Four-Stage Pipelined Register Controller

This block is a 16-bit controller for register transfers that takes one instruction on every clock edge. The instruction arrives on parallel input fields: a 3-bit opcode, two source register addresses, one destination register address and a 16-bit immediate. It works on a bank of eight 16-bit registers. The operations are copy, add, subtract, multiply, load-immediate, read-out, and compare with a jump flag when the operands are equal. A 32-bit result bus shows read-out values and arithmetic results, and multiply places its full product there.

Each instruction passes through four stages: capture, decode, operand read, and execute with writeback. The stages overlap, so an instruction accepted on one edge shows its effect on the outputs after the fourth edge, and the instruction behind it follows one cycle later. When an instruction reads a register that the instruction ahead of it is writing on the same edge, the value being written is forwarded to it. A dependent instruction issued right behind a producer therefore sees the new value. The program counter, the memories and jump targets belong to the surrounding system. This block only raises a flag when a jump is taken.

Top module: `pipe_ctl`

## Requirements
- R1: While rst_ni is low, all eight registers, result_o and jump_o read zero, and every pipeline stage is empty. The reset takes effect without waiting for a clock edge.
- R2: The opcode values are 000 nop, 001 move, 010 add, 011 sub, 100 mult, 101 loadi, 110 readi and 111 cjeq. Register addresses 000 to 111 select registers 0 to 7. An instruction sampled on clock edge n updates the registers and the outputs on edge n+3. A new instruction is accepted on every edge.
- R3: loadi writes imm_i into register[dst_i]. readi drives result_o with register[dst_i] zero-extended to 32 bits and changes no register.
- R4: move copies register[src_a_i] into register[dst_i] and drives result_o with that value zero-extended.
- R5: add writes the sum of register[src_a_i] and register[src_b_i], modulo 2^16, into register[dst_i]. sub writes register[src_a_i] minus register[src_b_i], modulo 2^16, into register[dst_i]. Both drive result_o with the stored 16-bit value zero-extended.
- R6: mult drives result_o with the full unsigned 32-bit product of register[src_a_i] and register[src_b_i]. Only the low 16 bits are written to register[dst_i].
- R7: cjeq raises jump_o for one cycle, in the cycle after it executes, when register[src_a_i] equals register[src_b_i]. Otherwise jump_o stays low. cjeq writes no register.
- R8: nop, loadi and cjeq leave result_o unchanged. nop writes no register and leaves jump_o low.
- R9: An instruction issued on the edge directly after a register-writing instruction sees that instruction's written value in any operand that names the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode of the incoming instruction |
| src_a_i | input | 3 | First source register address |
| src_b_i | input | 3 | Second source register address |
| dst_i | input | 3 | Destination register address; also the register that readi reads |
| imm_i | input | 16 | Immediate value for loadi |
| jump_o | output | 1 | Jump-taken flag from cjeq |
| result_o | output | 32 | Result bus |

## Verification
The bench targets back-to-back dependencies. A design without forwarding would hand a dependent add the stale operand and show the old sum. The subtraction that underflows and the multiply of two all-ones operands expose a design that truncates the product on the bus, writes the wrong half to the destination, or subtracts in the wrong order. Nop, loadi and cjeq are placed between read-outs to catch a bus that is cleared or overwritten when it should hold. Equal and unequal compares are checked cycle by cycle, which catches a jump flag that sticks or fires on inequality. A reset in the middle of a cycle is checked at once on the outputs, and afterwards through read-out, to catch a reset that is synchronous or leaves registers uncleared.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 3'b000,
    OP_MOVE  = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_MULT  = 3'b100,
    OP_LOADI = 3'b101,
    OP_READI = 3'b110,
    OP_CJEQ  = 3'b111
  } op_e;
endpackage

// File: rtl/pctl_regfile.sv
module pctl_regfile #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int NRD = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NRD*AW-1:0]   raddr_i,
  output logic [NRD*DW-1:0]   rdata_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs[i] <= '0;
      else if (we_i && (waddr_i == AW'(i)))          regs[i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p*DW +: DW] = regs[raddr_i[p*AW +: AW]];
  end
endmodule

// File: rtl/pctl_decode.sv
module pctl_decode #(
  parameter int AW = 3
) (
  input  pctl_pkg::op_e  op_i,
  input  logic [AW-1:0]  src_a_i,
  input  logic [AW-1:0]  src_b_i,
  input  logic [AW-1:0]  dst_i,
  output logic [AW-1:0]  rd_a_o,
  output logic [AW-1:0]  rd_b_o
);
  // readi reads through operand port a using the destination field
  assign rd_a_o = (op_i == pctl_pkg::OP_READI) ? dst_i : src_a_i;
  assign rd_b_o = src_b_i;
endmodule

// File: rtl/pctl_exec.sv
module pctl_exec #(
  parameter int DW = 16
) (
  input  pctl_pkg::op_e    op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [DW-1:0]    imm_i,
  output logic             we_o,
  output logic [DW-1:0]    wdata_o,
  output logic             res_upd_o,
  output logic [2*DW-1:0]  res_o,
  output logic             jmp_o
);
  import pctl_pkg::*;
  localparam int RW = 2 * DW;

  logic [RW-1:0] prod;
  logic [DW-1:0] sum, diff;

  assign prod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;

  always_comb begin
    we_o      = 1'b0;
    wdata_o   = a_i;
    res_upd_o = 1'b0;
    res_o     = {{DW{1'b0}}, a_i};
    jmp_o     = 1'b0;
    unique case (op_i)
      OP_MOVE: begin
        we_o = 1'b1; res_upd_o = 1'b1;
      end
      OP_ADD: begin
        we_o = 1'b1; res_upd_o = 1'b1;
        wdata_o = sum; res_o = {{DW{1'b0}}, sum};
      end
      OP_SUB: begin
        we_o = 1'b1; res_upd_o = 1'b1;
        wdata_o = diff; res_o = {{DW{1'b0}}, diff};
      end
      OP_MULT: begin
        we_o = 1'b1; res_upd_o = 1'b1;
        wdata_o = prod[DW-1:0]; res_o = prod;
      end
      OP_LOADI: begin
        we_o = 1'b1; wdata_o = imm_i;
      end
      OP_READI: res_upd_o = 1'b1;
      OP_CJEQ:  jmp_o = (a_i == b_i);
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [AW-1:0]     src_a_i,
  input  logic [AW-1:0]     src_b_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [DW-1:0]     imm_i,
  output logic              jump_o,
  output logic [2*DW-1:0]   result_o
);
  import pctl_pkg::*;
  localparam int RW  = 2 * DW;
  localparam int NRD = 2;

  // capture stage
  logic          f_vld;
  op_e           f_op;
  logic [AW-1:0] f_sa, f_sb, f_dst;
  logic [DW-1:0] f_imm;

  // decode stage
  logic          d_vld;
  op_e           d_op;
  logic [AW-1:0] d_dst;
  logic [DW-1:0] d_imm;
  logic [NRD*AW-1:0] d_rd;

  // operand stage
  logic          r_vld;
  op_e           r_op;
  logic [AW-1:0] r_dst;
  logic [DW-1:0] r_imm;
  logic [DW-1:0] r_opnd [NRD];

  logic [AW-1:0] dec_ra, dec_rb;
  logic [NRD*DW-1:0] rf_rdata;
  logic [DW-1:0] fwd_val [NRD];

  logic          x_we, x_res_upd, x_jmp;
  logic [DW-1:0] x_wdata;
  logic [RW-1:0] x_res;
  logic          wr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_vld <= 1'b0; f_op <= OP_NOP;
      f_sa <= '0; f_sb <= '0; f_dst <= '0; f_imm <= '0;
    end else begin
      f_vld <= 1'b1; f_op <= op_e'(op_i);
      f_sa <= src_a_i; f_sb <= src_b_i; f_dst <= dst_i; f_imm <= imm_i;
    end
  end

  pctl_decode #(.AW(AW)) u_dec (
    .op_i(f_op), .src_a_i(f_sa), .src_b_i(f_sb), .dst_i(f_dst),
    .rd_a_o(dec_ra), .rd_b_o(dec_rb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_vld <= 1'b0; d_op <= OP_NOP;
      d_dst <= '0; d_imm <= '0; d_rd <= '0;
    end else begin
      d_vld <= f_vld; d_op <= f_op;
      d_dst <= f_dst; d_imm <= f_imm; d_rd <= {dec_rb, dec_ra};
    end
  end

  pctl_regfile #(.DW(DW), .AW(AW), .NRD(NRD)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_en), .waddr_i(r_dst), .wdata_i(x_wdata),
    .raddr_i(d_rd), .rdata_o(rf_rdata)
  );

  // bypass the value retiring on this edge into the operand stage
  for (genvar p = 0; p < NRD; p++) begin : g_fwd
    assign fwd_val[p] = (wr_en && (r_dst == d_rd[p*AW +: AW]))
                        ? x_wdata : rf_rdata[p*DW +: DW];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_opnd[p] <= '0;
      else         r_opnd[p] <= fwd_val[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_vld <= 1'b0; r_op <= OP_NOP; r_dst <= '0; r_imm <= '0;
    end else begin
      r_vld <= d_vld; r_op <= d_op; r_dst <= d_dst; r_imm <= d_imm;
    end
  end

  pctl_exec #(.DW(DW)) u_exec (
    .op_i(r_op), .a_i(r_opnd[0]), .b_i(r_opnd[1]), .imm_i(r_imm),
    .we_o(x_we), .wdata_o(x_wdata),
    .res_upd_o(x_res_upd), .res_o(x_res), .jmp_o(x_jmp)
  );

  assign wr_en = r_vld & x_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      jump_o   <= 1'b0;
    end else begin
      if (r_vld && x_res_upd) result_o <= x_res;
      jump_o <= r_vld & x_jmp;
    end
  end
endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk #(
  parameter int DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            r_vld,
  input logic [2:0]      r_op,
  input logic [DW-1:0]   opnd_a,
  input logic [DW-1:0]   opnd_b,
  input logic            jump_o,
  input logic [2*DW-1:0] result_o
);
  localparam int RW = 2 * DW;
  logic [RW-1:0] chk_prod;
  assign chk_prod = {{DW{1'b0}}, opnd_a} * {{DW{1'b0}}, opnd_b};

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !jump_o));

  assert_jump_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_vld && r_op == 3'b111 && opnd_a == opnd_b) |=> jump_o);

  assert_jump_only_cjeq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(r_vld && r_op == 3'b111) |=> !jump_o);

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_vld && (r_op == 3'b000 || r_op == 3'b101 || r_op == 3'b111)) |=> $stable(result_o));

  assert_mult_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_vld && r_op == 3'b100) |=> (result_o == $past(chk_prod)));
endmodule

bind pipe_ctl pipe_ctl_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .r_vld(r_vld), .r_op(r_op),
  .opnd_a(r_opnd[0]), .opnd_b(r_opnd[1]),
  .jump_o(jump_o), .result_o(result_o)
);

// File: tb/pipe_ctl_test.sv
module pipe_ctl_test;
  localparam int DW = 16;
  localparam int AW = 3;

  typedef struct {
    int          due;
    logic [31:0] res;
    logic        jmp;
    string       tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] op_i = '0;
  logic [AW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [DW-1:0] imm_i = '0;
  logic jump_o;
  logic [31:0] result_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  exp_t sb [$];
  logic [15:0] m [8];
  logic [31:0] mres = '0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pipe_ctl #(.DW(DW), .AW(AW)) uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [2:0] sa, logic [2:0] sb_, logic [2:0] d,
                       logic [15:0] imm, string tag);
    exp_t e;
    logic [31:0] p;
    logic j;
    @(negedge clk_i);
    op_i = op; src_a_i = sa; src_b_i = sb_; dst_i = d; imm_i = imm;
    j = 1'b0;
    case (op)
      3'b001: begin m[d] = m[sa]; mres = {16'h0, m[d]}; end
      3'b010: begin m[d] = m[sa] + m[sb_]; mres = {16'h0, m[d]}; end
      3'b011: begin m[d] = m[sa] - m[sb_]; mres = {16'h0, m[d]}; end
      3'b100: begin p = {16'h0, m[sa]} * {16'h0, m[sb_]}; m[d] = p[15:0]; mres = p; end
      3'b101: m[d] = imm;
      3'b110: mres = {16'h0, m[d]};
      3'b111: j = (m[sa] == m[sb_]);
      default: ;
    endcase
    e.due = cyc + 4; e.res = mres; e.jmp = j; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare outputs in the cycle each instruction retires
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      check({sb[0].tag, " result"}, result_o, sb[0].res);
      check({sb[0].tag, " jump"}, {31'h0, jump_o}, {31'h0, sb[0].jmp});
      void'(sb.pop_front());
    end
  end

  task automatic drain();
    repeat (6) @(negedge clk_i);
    check("R2 scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset result", result_o, 0);
    check("R1 reset jump", {31'h0, jump_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) issue(3'b110, 0, 0, 3'(i), 0, "R1 reg clear");

    // loadi holds result; back-to-back dependent add (R9)
    issue(3'b101, 0, 0, 3'd0, 16'h0005, "R8 loadi hold");
    issue(3'b101, 0, 0, 3'd1, 16'h0007, "R3 loadi");
    issue(3'b010, 3'd0, 3'd1, 3'd2, 0, "R9 fwd add");
    issue(3'b010, 3'd2, 3'd2, 3'd2, 0, "R9 fwd self add");
    issue(3'b110, 0, 0, 3'd2, 0, "R3 readi");
    // sub underflow and operand order (R5)
    issue(3'b011, 3'd0, 3'd1, 3'd3, 0, "R5 sub wrap");
    issue(3'b011, 3'd1, 3'd0, 3'd4, 0, "R5 sub order");
    issue(3'b000, 0, 0, 0, 0, "R8 nop hold");
    issue(3'b110, 0, 0, 3'd3, 0, "R5 readi sub");
    issue(3'b101, 0, 0, 3'd5, 16'hffff, "R3 loadi max");
    issue(3'b101, 0, 0, 3'd6, 16'hffff, "R3 loadi max");
    issue(3'b100, 3'd5, 3'd6, 3'd7, 0, "R6 mult full");
    issue(3'b110, 0, 0, 3'd7, 0, "R6 mult low half");
    issue(3'b010, 3'd5, 3'd6, 3'd4, 0, "R5 add wrap");
    issue(3'b001, 3'd4, 0, 3'd0, 0, "R4 move");
    issue(3'b110, 0, 0, 3'd0, 0, "R4 readi moved");
    // compare-and-jump (R7)
    issue(3'b111, 3'd5, 3'd6, 0, 0, "R7 cjeq equal");
    issue(3'b000, 0, 0, 0, 0, "R7 jump one cycle");
    issue(3'b111, 3'd0, 3'd1, 0, 0, "R7 cjeq unequal");
    issue(3'b111, 3'd5, 3'd6, 0, 0, "R7 cjeq equal again");
    issue(3'b111, 3'd6, 3'd5, 0, 0, "R7 cjeq back-to-back");
    issue(3'b101, 0, 0, 3'd1, 16'h00ab, "R9 loadi producer");
    issue(3'b111, 3'd1, 3'd1, 0, 0, "R9 fwd cjeq");
    issue(3'b110, 0, 0, 3'd5, 0, "R7 no reg change");
    issue(3'b110, 0, 0, 3'd1, 0, "R8 nop no reg change");
    issue(3'b000, 0, 0, 0, 0, "R8 nop");
    drain();

    // mid-cycle asynchronous reset (R1)
    issue(3'b101, 0, 0, 3'd0, 16'h1234, "R3 loadi");
    issue(3'b110, 0, 0, 3'd0, 0, "R3 readi pre-reset");
    drain();
    #2 rst_ni = 1'b0;
    #1;
    check("R1 async result", result_o, 0);
    check("R1 async jump", {31'h0, jump_o}, 0);
    for (int i = 0; i < 8; i++) m[i] = '0;
    mres = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    issue(3'b110, 0, 0, 3'd0, 0, "R1 reg cleared");
    issue(3'b110, 0, 0, 3'd7, 0, "R1 reg cleared");
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule